// File: doc/BRIEF.md
# Seven-Segment and GPIO Output Peripheral

This block hangs off a simple processor register bus and owns one 8-bit output port. Software either drives the port as a plain general-purpose output register, or hands the port to a seven-segment encoder. The encoder turns a data byte into a segment pattern in one of three ways: as a hexadecimal digit, as a text character, or as a raw pattern taken bit for bit.

Three registers hold the state: a port value, a display byte and a control word. The control word picks the source of the port, the encoding and the output polarity. A single register write is enough to switch modes, so firmware can move between a status LED byte and a display character at any time. The port is combinational from the registers. It therefore shows a new setting directly after the clock edge that stores the write.

Top module: `segdisp_periph`

## Requirements
- R1: After reset, all three registers read 0 and the output port is 0x00.
- R2: Writes whose address is 0x1000_0000 set the port register, 0x1000_0004 the display byte, and 0x1000_0008 the control word. Each register stores the low bits of the write data (8, 8 and 4 bits) and reads them back at its own address with the upper bits zero. Other addresses read 0, and writes to them change nothing.
- R3: While control bit 0 (display enable) is 0, the port equals the port register, with no inversion.
- R4: With display enabled and control bits 1 and 2 both 0, the low nibble of the display byte is shown as a hex digit. The upper nibble is ignored and bit 7 (decimal point) is 0.
- R5: With display enabled, bit 1 set and bit 2 clear, the byte is a character. Digits show like hex. Letters show one glyph per letter regardless of case. '-' shows segment g only (0x40) and '_' shows segment d only (0x08). The decimal point is off.
- R6: In character mode, any other byte, including all values at or above 0x80, gives a blank pattern (0x00 before polarity).
- R7: With display enabled and bit 2 set, the port carries the display byte unchanged, including bit 7.
- R8: When bits 1 and 2 are both set, raw mode wins over character mode.
- R9: With display enabled, control bit 3 inverts all eight port bits. With bit 3 clear, a 1 drives a segment on.
- R10: The port shows the effect of a write directly after the clock edge that stores it. Port bits 0 to 6 are segments a to g.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| port_out | output | 8 | Shared port / segment output |

## Verification
The hardest cases are the combinations of control bits that overlap: raw and character mode set together, and inversion applied or not applied, depending on whether the display owns the port. The port register must also stay hidden behind an enabled display, yet reappear unchanged once the display is disabled. Random rounds therefore write all three registers with independent random values, including every one of the sixteen control words. The display byte is biased towards printable characters so that every glyph class is reached. Directed steps then target the priority, blank-glyph and address-alias cases.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;

  typedef struct packed {
    logic inv;    // bit 3
    logic raw;    // bit 2
    logic ascii;  // bit 1
    logic en;     // bit 0
  } seg_ctrl_t;

  typedef enum logic [1:0] {
    ENC_HEX   = 2'd0,
    ENC_CHAR  = 2'd1,
    ENC_RAW   = 2'd2
  } seg_mode_e;

  function automatic logic [7:0] hex_glyph(input logic [3:0] nib);
    logic [7:0] g;
    case (nib)
      4'h0: g = 8'h3F;
      4'h1: g = 8'h06;
      4'h2: g = 8'h5B;
      4'h3: g = 8'h4F;
      4'h4: g = 8'h66;
      4'h5: g = 8'h6D;
      4'h6: g = 8'h7D;
      4'h7: g = 8'h07;
      4'h8: g = 8'h7F;
      4'h9: g = 8'h6F;
      4'hA: g = 8'h77;
      4'hB: g = 8'h7C;
      4'hC: g = 8'h39;
      4'hD: g = 8'h5E;
      4'hE: g = 8'h79;
      default: g = 8'h71;
    endcase
    return g;
  endfunction

  function automatic logic [7:0] letter_glyph(input logic [4:0] idx);
    logic [7:0] g;
    case (idx)
      5'd0:  g = 8'h77;
      5'd1:  g = 8'h7C;
      5'd2:  g = 8'h39;
      5'd3:  g = 8'h5E;
      5'd4:  g = 8'h79;
      5'd5:  g = 8'h71;
      5'd6:  g = 8'h3D;
      5'd7:  g = 8'h76;
      5'd8:  g = 8'h30;
      5'd9:  g = 8'h1E;
      5'd10: g = 8'h75;
      5'd11: g = 8'h38;
      5'd12: g = 8'h15;
      5'd13: g = 8'h54;
      5'd14: g = 8'h5C;
      5'd15: g = 8'h73;
      5'd16: g = 8'h67;
      5'd17: g = 8'h50;
      5'd18: g = 8'h2D;
      5'd19: g = 8'h78;
      5'd20: g = 8'h3E;
      5'd21: g = 8'h1C;
      5'd22: g = 8'h2A;
      5'd23: g = 8'h64;
      5'd24: g = 8'h6E;
      default: g = 8'h1B;
    endcase
    return g;
  endfunction

  function automatic logic [7:0] char_glyph(input logic [7:0] ch);
    logic [7:0] up;
    logic [7:0] g;
    up = ch & 8'hDF;
    if (ch >= 8'h30 && ch <= 8'h39)      g = hex_glyph(ch[3:0]);
    else if (up >= 8'h41 && up <= 8'h5A) g = letter_glyph(5'(up - 8'h41));
    else if (ch == 8'h2D)                g = 8'h40;
    else if (ch == 8'h5F)                g = 8'h08;
    else                                 g = 8'h00;
    return g;
  endfunction

endpackage

// File: rtl/seg_regs.sv
module seg_regs
  import segdisp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PORT_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 32'h1000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata,
  output logic [PORT_W-1:0] gpio_q,
  output logic [PORT_W-1:0] data_q,
  output seg_ctrl_t         ctrl_q
);
  localparam int CTRL_W = $bits(seg_ctrl_t);
  localparam logic [ADDR_W-1:0] A_GPIO = BASE;
  localparam logic [ADDR_W-1:0] A_DATA = BASE + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CTRL = BASE + ADDR_W'(8);

  logic hit_gpio, hit_data, hit_ctrl;
  logic wr_gpio, wr_data, wr_ctrl;
  logic unused_wdata_hi;

  assign hit_gpio = (addr == A_GPIO);
  assign hit_data = (addr == A_DATA);
  assign hit_ctrl = (addr == A_CTRL);
  assign wr_gpio  = we && hit_gpio;
  assign wr_data  = we && hit_data;
  assign wr_ctrl  = we && hit_ctrl;
  assign unused_wdata_hi = ^wdata[DATA_W-1:PORT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpio_q <= '0;
      data_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_gpio) gpio_q <= wdata[PORT_W-1:0];
      if (wr_data) data_q <= wdata[PORT_W-1:0];
      if (wr_ctrl) ctrl_q <= seg_ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_gpio)      rdata[PORT_W-1:0] = gpio_q;
    else if (hit_data) rdata[PORT_W-1:0] = data_q;
    else if (hit_ctrl) rdata[CTRL_W-1:0] = ctrl_q;
  end

  // R2: registers change only on a matching write
  a_r2_gpio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_gpio |=> $stable(gpio_q));
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));
  a_r2_data_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> data_q == $past(wdata[PORT_W-1:0]));
  a_r2_onehot_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_gpio, hit_data, hit_ctrl}));

endmodule

// File: rtl/seg_encoder.sv
module seg_encoder
  import segdisp_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  seg_ctrl_t         ctrl,
  input  logic [PORT_W-1:0] data,
  output seg_mode_e         mode,
  output logic [PORT_W-1:0] seg
);
  // R8: raw checked before character mode
  always_comb begin
    if (ctrl.raw)        mode = ENC_RAW;
    else if (ctrl.ascii) mode = ENC_CHAR;
    else                 mode = ENC_HEX;
  end

  always_comb begin
    case (mode)
      ENC_RAW:  seg = data;
      ENC_CHAR: seg = char_glyph(data);
      default:  seg = hex_glyph(data[3:0]);
    endcase
  end

  // R4/R5: decoded glyphs never light the decimal point
  always_comb begin
    if (mode != ENC_RAW) a_r4_dp_off: assert (seg[PORT_W-1] == 1'b0);
  end

endmodule

// File: rtl/seg_portmux.sv
module seg_portmux
  import segdisp_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  seg_ctrl_t         ctrl,
  input  logic [PORT_W-1:0] gpio,
  input  logic [PORT_W-1:0] seg,
  output logic [PORT_W-1:0] port
);
  logic [PORT_W-1:0] seg_pol;

  // R9: per-bit polarity stage
  for (genvar i = 0; i < PORT_W; i++) begin : g_pol
    assign seg_pol[i] = seg[i] ^ ctrl.inv;
  end

  assign port = ctrl.en ? seg_pol : gpio;

endmodule

// File: rtl/segdisp_periph.sv
module segdisp_periph
  import segdisp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PORT_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 32'h1000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [PORT_W-1:0] port_out
);
  logic [PORT_W-1:0] gpio_q, data_q, enc_seg;
  seg_ctrl_t         ctrl_q;
  seg_mode_e         enc_mode;

  seg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W), .BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .rdata(bus_rdata), .gpio_q(gpio_q), .data_q(data_q), .ctrl_q(ctrl_q)
  );

  seg_encoder #(.PORT_W(PORT_W)) u_enc (
    .ctrl(ctrl_q), .data(data_q), .mode(enc_mode), .seg(enc_seg)
  );

  seg_portmux #(.PORT_W(PORT_W)) u_mux (
    .ctrl(ctrl_q), .gpio(gpio_q), .seg(enc_seg), .port(port_out)
  );

  // R3: display off hands the port to the GPIO register untouched
  a_r3_gpio_owns: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |-> port_out == gpio_q);
  // R7/R8: raw wins and passes the byte straight through
  a_r7_raw_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.en && ctrl_q.raw && !ctrl_q.inv) |-> port_out == data_q);
  a_r8_raw_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.raw |-> enc_mode == ENC_RAW);
  // R9: inversion is the complement of the encoder pattern
  a_r9_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.en && ctrl_q.inv) |-> port_out == ~enc_seg);
  // R10: port only moves after a write
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(port_out));

endmodule

// File: tb/tb_segdisp_periph.sv
module tb_segdisp_periph;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  port_out;

  int n_checks = 0;
  int n_fails  = 0;

  localparam logic [31:0] A_GPIO = 32'h1000_0000;
  localparam logic [31:0] A_DATA = 32'h1000_0004;
  localparam logic [31:0] A_CTRL = 32'h1000_0008;

  always #2.5 clk = ~clk;

  segdisp_periph dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .port_out(port_out)
  );

  logic [7:0] digit_tab [16];
  logic [7:0] alpha_tab [26];

  function automatic logic [7:0] glyph_char(input logic [7:0] c);
    if (c inside {[8'h30:8'h39]}) return digit_tab[c - 8'h30];
    if (c inside {[8'h41:8'h5A]}) return alpha_tab[c - 8'h41];
    if (c inside {[8'h61:8'h7A]}) return alpha_tab[c - 8'h61];
    if (c == "-") return 8'b0100_0000;
    if (c == "_") return 8'b0000_1000;
    return 8'h00;
  endfunction

  function automatic logic [7:0] model_port(input logic [3:0] ctl, input logic [7:0] dat,
                                           input logic [7:0] gp);
    logic [7:0] p;
    if (!ctl[0]) return gp;
    if (ctl[2])      p = dat;
    else if (ctl[1]) p = glyph_char(dat);
    else             p = digit_tab[dat[3:0]];
    return ctl[3] ? ~p : p;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 32'h0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL R10: watchdog expired, actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [3:0]  c_m;
    logic [7:0]  d_m, g_m;
    int unsigned seed_init;
    digit_tab = '{8'h3F, 8'h06, 8'h5B, 8'h4F, 8'h66, 8'h6D, 8'h7D, 8'h07,
                  8'h7F, 8'h6F, 8'h77, 8'h7C, 8'h39, 8'h5E, 8'h79, 8'h71};
    alpha_tab = '{8'h77, 8'h7C, 8'h39, 8'h5E, 8'h79, 8'h71, 8'h3D, 8'h76, 8'h30,
                  8'h1E, 8'h75, 8'h38, 8'h15, 8'h54, 8'h5C, 8'h73, 8'h67, 8'h50,
                  8'h2D, 8'h78, 8'h3E, 8'h1C, 8'h2A, 8'h64, 8'h6E, 8'h1B};
    seed_init = $urandom(32'd20240611);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 port", {24'h0, port_out}, 32'h0);
    rd(A_GPIO, rv); check("R1 gpio", rv, 32'h0);
    rd(A_DATA, rv); check("R1 data", rv, 32'h0);
    rd(A_CTRL, rv); check("R1 ctrl", rv, 32'h0);

    // R2 readback widths and unmapped addresses
    wr(A_GPIO, 32'hDEAD_BEA5); rd(A_GPIO, rv); check("R2 gpio rb", rv, 32'hA5);
    wr(A_DATA, 32'h1234_5678); rd(A_DATA, rv); check("R2 data rb", rv, 32'h78);
    wr(A_CTRL, 32'hFFFF_FFF4); rd(A_CTRL, rv); check("R2 ctrl rb", rv, 32'h4);
    wr(A_CTRL, 32'h0);
    wr(32'h1000_000C, 32'hFF); rd(32'h1000_000C, rv); check("R2 unmapped rd", rv, 32'h0);
    wr(32'h2000_0000, 32'h3C);
    rd(A_GPIO, rv); check("R2 alias no write", rv, 32'hA5);
    // R3 GPIO passes without inversion
    check("R3 gpio port", {24'h0, port_out}, 32'hA5);
    wr(A_CTRL, 32'h8);
    check("R3 inv ignored", {24'h0, port_out}, 32'hA5);

    // R4 hex ignores upper nibble
    wr(A_DATA, 32'hF3); wr(A_CTRL, 32'h1);
    check("R4 hex 3", {24'h0, port_out}, 32'h4F);
    // R10 effect right after the write edge
    @(negedge clk);
    bus_addr = A_DATA; bus_wdata = 32'h0B; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
    check("R10 same edge", {24'h0, port_out}, 32'h7C);

    // R5 character mode, case folding
    wr(A_CTRL, 32'h3);
    wr(A_DATA, "h"); check("R5 lower h", {24'h0, port_out}, {24'h0, alpha_tab[7]});
    wr(A_DATA, "H"); check("R5 upper H", {24'h0, port_out}, {24'h0, alpha_tab[7]});
    wr(A_DATA, "7"); check("R5 digit", {24'h0, port_out}, 32'h07);
    wr(A_DATA, "-"); check("R5 dash", {24'h0, port_out}, 32'h40);
    // R6 blank glyphs
    wr(A_DATA, 32'hC8); check("R6 high byte", {24'h0, port_out}, 32'h00);
    wr(A_DATA, "@");    check("R6 at sign", {24'h0, port_out}, 32'h00);
    wr(A_CTRL, 32'hB);  check("R6 blank inverted", {24'h0, port_out}, 32'hFF);

    // R7 raw incl decimal point, R8 priority
    wr(A_DATA, 32'h81); wr(A_CTRL, 32'h5);
    check("R7 raw", {24'h0, port_out}, 32'h81);
    wr(A_DATA, "A"); wr(A_CTRL, 32'h7);
    check("R8 raw beats char", {24'h0, port_out}, 32'h41);
    // R9 inversion
    wr(A_CTRL, 32'hF);
    check("R9 raw inverted", {24'h0, port_out}, 32'hBE);
    wr(A_CTRL, 32'h9); wr(A_DATA, 32'h08);
    check("R9 hex inverted", {24'h0, port_out}, 32'h80);
    // R3 GPIO reappears after disable
    wr(A_CTRL, 32'h0);
    check("R3 gpio kept", {24'h0, port_out}, 32'hA5);

    // Random rounds
    for (int i = 0; i < 400; i++) begin
      c_m = 4'($urandom);
      d_m = ($urandom % 4 != 0) ? 8'(32'h20 + $urandom % 96) : 8'($urandom);
      g_m = 8'($urandom);
      wr(A_GPIO, $urandom);
      bus_wdata = '0;
      wr(A_GPIO, {$urandom, g_m} >> 0);
      wr(A_DATA, {24'($urandom), d_m});
      wr(A_CTRL, {28'($urandom), c_m});
      check("R4/R5/R7/R9 random port", {24'h0, port_out}, {24'h0, model_port(c_m, d_m, g_m)});
      if (i % 8 == 0) begin
        rd(A_DATA, rv); check("R2 random data rb", rv, {24'h0, d_m});
        rd(A_CTRL, rv); check("R2 random ctrl rb", rv, {28'h0, c_m});
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule